// File: doc/BRIEF.md
# Load-Store Data Bus Requester

This block sits between a processor's load-store stage and a 32-bit data memory port. The core hands it one access at a time: an address, a write enable, byte enables and write data. The block raises a request on the memory side. It keeps every request field steady until the memory grants the request. It then waits for the one-cycle response, which carries read data and an error flag.

A successful load returns its data to the core with a one-cycle valid pulse. A successful store returns a one-cycle completion pulse. A failed access of either kind raises a one-cycle exception pulse. That pulse carries the faulting address and whether the access was a store, and it cannot be masked.

A new command may be accepted in the same cycle that the current request is granted. This keeps the request line high across consecutive granted cycles. Up to `DEPTH` granted accesses may wait for their responses. They are held in a small in-order queue that records each access's type and address. Responses are matched to requests strictly in grant order.

The request side is a two-state machine. In `RQ_IDLE` no request is driven. In `RQ_WAIT_GNT` the request line is high with the held fields. Its transitions are:
- `T_ISSUE`: from `RQ_IDLE` to `RQ_WAIT_GNT`, taken when a command is accepted.
- `T_HOLD`: from `RQ_WAIT_GNT` back to itself, taken while no grant has arrived.
- `T_CHAIN`: from `RQ_WAIT_GNT` back to itself, taken on a grant in the same cycle that a new command is accepted.
- `T_RELEASE`: from `RQ_WAIT_GNT` to `RQ_IDLE`, taken on a grant with no new command.

The response side has four states, entered from any state on every clock edge:
- `RS_QUIET`: no response arrived.
- `RS_LOAD_OK`: a successful load response arrived.
- `RS_STORE_OK`: a successful store response arrived.
- `RS_FAULT`: an error response arrived.

Top module: `lsu_bus_req`

## Requirements
- R1: After reset, mem_req_o, busy_o, ld_valid_o, st_done_o and exc_o are 0, ld_data_o is 0, and cmd_ready_o is 1.
- R2: A command is accepted on a clock edge where cmd_valid_i and cmd_ready_o are both 1. From the next cycle, mem_req_o is 1 and mem_addr_o, mem_we_o, mem_be_o and mem_wdata_o equal that command's fields.
- R3: While mem_req_o is 1 and mem_gnt_i is 0, the next cycle still has mem_req_o at 1 with all four request fields unchanged. A grant in the first cycle of a request is accepted.
- R4: If a request is granted and no command is accepted on the same edge, mem_req_o is 0 in the next cycle.
- R5: If a command is accepted on the edge where the current request is granted, mem_req_o stays 1 in the next cycle and carries the new command's fields.
- R6: At most DEPTH granted accesses are ever unanswered. With DEPTH unanswered and no response in the cycle, cmd_ready_o and mem_req_o are 0. With no request raised and fewer than DEPTH unanswered, cmd_ready_o is 1.
- R7: A response (mem_rvalid_i at 1) with mem_err_i at 0 for a load produces ld_valid_o at 1 for exactly the next cycle, with ld_data_o equal to the mem_rdata_i sampled with the response.
- R8: A response with mem_err_i at 0 for a store produces st_done_o at 1 for exactly the next cycle. Its mem_rdata_i is ignored: ld_data_o changes only in a cycle where ld_valid_o is 1.
- R9: A response with mem_err_i at 1 produces exc_o at 1 for exactly the next cycle. In that cycle exc_addr_o is the access's address and exc_store_o is 1 for a store and 0 for a load. No ld_valid_o or st_done_o is raised and ld_data_o is unchanged. There is no way to suppress it, and at most one of ld_valid_o, st_done_o and exc_o is 1 in any cycle.
- R10: Responses are matched to granted requests in grant order, including responses in consecutive cycles.
- R11: busy_o is 1 exactly when a request is raised but not yet granted, or a granted access is unanswered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Core offers an access |
| cmd_ready_o | output | 1 | Block accepts the offered access this cycle |
| cmd_we_i | input | 1 | Access is a store (1) or a load (0) |
| cmd_addr_i | input | AW | Access address |
| cmd_be_i | input | BW | Byte enables |
| cmd_wdata_i | input | DW | Store data |
| mem_req_o | output | 1 | Request to memory |
| mem_gnt_i | input | 1 | Memory has taken the request |
| mem_addr_o | output | AW | Request address |
| mem_we_o | output | 1 | Request is a write |
| mem_be_o | output | BW | Request byte enables |
| mem_wdata_o | output | DW | Request write data |
| mem_rvalid_i | input | 1 | One-cycle response strobe |
| mem_rdata_i | input | DW | Response read data |
| mem_err_i | input | 1 | Response error flag |
| ld_valid_o | output | 1 | Load data pulse |
| ld_data_o | output | DW | Most recent successful load data |
| st_done_o | output | 1 | Store completion pulse |
| exc_o | output | 1 | Bus error exception pulse |
| exc_addr_o | output | AW | Faulting address, valid with exc_o |
| exc_store_o | output | 1 | Faulting access was a store |
| busy_o | output | 1 | A request is ungranted or a response is pending |

## Verification
The bench builds the block with its default parameters: 32-bit address and data, 4 byte enables and a queue depth of 2. With a depth of 2, the bench's slowest response setting is enough to fill the queue. That makes the stalled ready and the dropped request reachable within a few cycles. It also lets back-to-back grants stay in flight with responses arriving in consecutive cycles. The grant delay is varied from zero upward. The response latency is varied from one cycle to several. Error flags are applied never, on alternate accesses, and on every access. Together these settings cover chained requests, the full queue and exception ordering.

// File: rtl/lsu_bus_pkg.sv
`timescale 1ns/1ps
package lsu_bus_pkg;

    // Request side: whether a request is being driven on the bus.
    typedef enum logic {
        RQ_IDLE     = 1'b0,
        RQ_WAIT_GNT = 1'b1
    } rq_state_e;

    // Response side: what the last clock edge delivered to the core.
    typedef enum logic [1:0] {
        RS_QUIET    = 2'd0,
        RS_LOAD_OK  = 2'd1,
        RS_STORE_OK = 2'd2,
        RS_FAULT    = 2'd3
    } rs_state_e;

endpackage

// File: rtl/lsu_txn_queue.sv
`timescale 1ns/1ps
module lsu_txn_queue #(
    parameter int W     = 33,
    parameter int DEPTH = 2,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          push_i,
    input  logic [W-1:0]  push_data_i,
    input  logic          pop_i,
    output logic [W-1:0]  head_o,
    output logic [CW-1:0] count_o,
    output logic          empty_o
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [PW-1:0] wr_ptr_q;
    logic [PW-1:0] rd_ptr_q;
    logic [CW-1:0] count_q;
    logic [W-1:0]  slot_w [DEPTH];

    function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
        return (int'(p) == DEPTH - 1) ? '0 : p + 1'b1;
    endfunction

    // One register per slot; a slot loads only when the write pointer selects it.
    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_slot
            logic [W-1:0] data_q;
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) begin
                    data_q <= '0;
                end else if (push_i && (int'(wr_ptr_q) == i)) begin
                    data_q <= push_data_i;
                end
            end
            assign slot_w[i] = data_q;
        end
    endgenerate

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            count_q  <= '0;
        end else begin
            if (push_i) begin
                wr_ptr_q <= ptr_next(wr_ptr_q);
            end
            if (pop_i) begin
                rd_ptr_q <= ptr_next(rd_ptr_q);
            end
            count_q <= count_q + CW'(push_i) - CW'(pop_i);
        end
    end

    assign head_o  = slot_w[rd_ptr_q];
    assign count_o = count_q;
    assign empty_o = (count_q == '0);

endmodule

// File: rtl/lsu_req_fsm.sv
`timescale 1ns/1ps
module lsu_req_fsm
    import lsu_bus_pkg::*;
#(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int BW    = DW / 8,
    parameter int DEPTH = 2,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          cmd_valid_i,
    output logic          cmd_ready_o,
    input  logic          cmd_we_i,
    input  logic [AW-1:0] cmd_addr_i,
    input  logic [BW-1:0] cmd_be_i,
    input  logic [DW-1:0] cmd_wdata_i,
    input  logic          mem_gnt_i,
    output logic          mem_req_o,
    output logic [AW-1:0] mem_addr_o,
    output logic          mem_we_o,
    output logic [BW-1:0] mem_be_o,
    output logic [DW-1:0] mem_wdata_o,
    input  logic [CW-1:0] q_count_i,
    input  logic          q_pop_i,
    output logic          q_push_o,
    output logic          pending_o
);
    rq_state_e     state_q, state_d;
    logic [AW-1:0] addr_q;
    logic          we_q;
    logic [BW-1:0] be_q;
    logic [DW-1:0] wdata_q;

    logic room_idle;
    logic room_chain;
    logic take;
    logic granted;

    // Room checks: when idle, the queue must not be full. When chaining, the
    // grant in flight plus the remaining entries, less any response popping
    // this cycle, must still leave a slot.
    always_comb begin
        room_idle  = int'(q_count_i) < DEPTH;
        room_chain = (int'(q_count_i) + 1) < (DEPTH + int'(q_pop_i));
        granted    = (state_q == RQ_WAIT_GNT) && mem_gnt_i;
        unique case (state_q)
            RQ_IDLE:     cmd_ready_o = room_idle;
            RQ_WAIT_GNT: cmd_ready_o = mem_gnt_i && room_chain;
            default:     cmd_ready_o = 1'b0;
        endcase
        take = cmd_valid_i && cmd_ready_o;
    end

    // Next-state selection (T_ISSUE, T_HOLD, T_CHAIN, T_RELEASE).
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RQ_IDLE: begin
                if (take) begin
                    state_d = RQ_WAIT_GNT;   // T_ISSUE
                end
            end
            RQ_WAIT_GNT: begin
                if (!mem_gnt_i) begin
                    state_d = RQ_WAIT_GNT;   // T_HOLD
                end else if (take) begin
                    state_d = RQ_WAIT_GNT;   // T_CHAIN
                end else begin
                    state_d = RQ_IDLE;       // T_RELEASE
                end
            end
            default: state_d = RQ_IDLE;
        endcase
    end

    // State register and held request fields.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= RQ_IDLE;
            addr_q  <= '0;
            we_q    <= 1'b0;
            be_q    <= '0;
            wdata_q <= '0;
        end else begin
            state_q <= state_d;
            if (take) begin
                addr_q  <= cmd_addr_i;
                we_q    <= cmd_we_i;
                be_q    <= cmd_be_i;
                wdata_q <= cmd_wdata_i;
            end
        end
    end

    // Outputs decoded from the state.
    always_comb begin
        mem_req_o   = (state_q == RQ_WAIT_GNT);
        mem_addr_o  = addr_q;
        mem_we_o    = we_q;
        mem_be_o    = be_q;
        mem_wdata_o = wdata_q;
        q_push_o    = granted;
        pending_o   = (state_q == RQ_WAIT_GNT);
    end

endmodule

// File: rtl/lsu_rsp_unit.sv
`timescale 1ns/1ps
module lsu_rsp_unit
    import lsu_bus_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          mem_rvalid_i,
    input  logic [DW-1:0] mem_rdata_i,
    input  logic          mem_err_i,
    input  logic          q_empty_i,
    input  logic          head_we_i,
    input  logic [AW-1:0] head_addr_i,
    output logic          q_pop_o,
    output logic          ld_valid_o,
    output logic [DW-1:0] ld_data_o,
    output logic          st_done_o,
    output logic          exc_o,
    output logic [AW-1:0] exc_addr_o,
    output logic          exc_store_o
);
    rs_state_e     state_q, state_d;
    logic [DW-1:0] ld_data_q;
    logic [AW-1:0] exc_addr_q;
    logic          exc_store_q;
    logic          accept;

    // A response counts only when an access is outstanding.
    always_comb begin
        accept  = mem_rvalid_i && !q_empty_i;
        state_d = RS_QUIET;
        if (accept) begin
            if (mem_err_i) begin
                state_d = RS_FAULT;
            end else if (head_we_i) begin
                state_d = RS_STORE_OK;
            end else begin
                state_d = RS_LOAD_OK;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q     <= RS_QUIET;
            ld_data_q   <= '0;
            exc_addr_q  <= '0;
            exc_store_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_d == RS_LOAD_OK) begin
                ld_data_q <= mem_rdata_i;
            end
            if (state_d == RS_FAULT) begin
                exc_addr_q  <= head_addr_i;
                exc_store_q <= head_we_i;
            end
        end
    end

    always_comb begin
        q_pop_o     = accept;
        ld_valid_o  = 1'b0;
        st_done_o   = 1'b0;
        exc_o       = 1'b0;
        unique case (state_q)
            RS_QUIET:    ;
            RS_LOAD_OK:  ld_valid_o = 1'b1;
            RS_STORE_OK: st_done_o  = 1'b1;
            RS_FAULT:    exc_o      = 1'b1;
            default:     ;
        endcase
        ld_data_o   = ld_data_q;
        exc_addr_o  = exc_addr_q;
        exc_store_o = exc_store_q;
    end

endmodule

// File: rtl/lsu_bus_req.sv
`timescale 1ns/1ps
module lsu_bus_req #(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int BW    = DW / 8,
    parameter int DEPTH = 2
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          cmd_valid_i,
    output logic          cmd_ready_o,
    input  logic          cmd_we_i,
    input  logic [AW-1:0] cmd_addr_i,
    input  logic [BW-1:0] cmd_be_i,
    input  logic [DW-1:0] cmd_wdata_i,
    output logic          mem_req_o,
    input  logic          mem_gnt_i,
    output logic [AW-1:0] mem_addr_o,
    output logic          mem_we_o,
    output logic [BW-1:0] mem_be_o,
    output logic [DW-1:0] mem_wdata_o,
    input  logic          mem_rvalid_i,
    input  logic [DW-1:0] mem_rdata_i,
    input  logic          mem_err_i,
    output logic          ld_valid_o,
    output logic [DW-1:0] ld_data_o,
    output logic          st_done_o,
    output logic          exc_o,
    output logic [AW-1:0] exc_addr_o,
    output logic          exc_store_o,
    output logic          busy_o
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam int QW = AW + 1;

    logic          q_push;
    logic          q_pop;
    logic [QW-1:0] q_head;
    logic [CW-1:0] q_count;
    logic          q_empty;
    logic          pending;

    lsu_req_fsm #(
        .AW(AW), .DW(DW), .BW(BW), .DEPTH(DEPTH), .CW(CW)
    ) u_req (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .cmd_valid_i (cmd_valid_i),
        .cmd_ready_o (cmd_ready_o),
        .cmd_we_i    (cmd_we_i),
        .cmd_addr_i  (cmd_addr_i),
        .cmd_be_i    (cmd_be_i),
        .cmd_wdata_i (cmd_wdata_i),
        .mem_gnt_i   (mem_gnt_i),
        .mem_req_o   (mem_req_o),
        .mem_addr_o  (mem_addr_o),
        .mem_we_o    (mem_we_o),
        .mem_be_o    (mem_be_o),
        .mem_wdata_o (mem_wdata_o),
        .q_count_i   (q_count),
        .q_pop_i     (q_pop),
        .q_push_o    (q_push),
        .pending_o   (pending)
    );

    lsu_txn_queue #(
        .W(QW), .DEPTH(DEPTH), .CW(CW)
    ) u_queue (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .push_i      (q_push),
        .push_data_i ({mem_we_o, mem_addr_o}),
        .pop_i       (q_pop),
        .head_o      (q_head),
        .count_o     (q_count),
        .empty_o     (q_empty)
    );

    lsu_rsp_unit #(
        .AW(AW), .DW(DW)
    ) u_rsp (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .mem_rvalid_i (mem_rvalid_i),
        .mem_rdata_i  (mem_rdata_i),
        .mem_err_i    (mem_err_i),
        .q_empty_i    (q_empty),
        .head_we_i    (q_head[AW]),
        .head_addr_i  (q_head[AW-1:0]),
        .q_pop_o      (q_pop),
        .ld_valid_o   (ld_valid_o),
        .ld_data_o    (ld_data_o),
        .st_done_o    (st_done_o),
        .exc_o        (exc_o),
        .exc_addr_o   (exc_addr_o),
        .exc_store_o  (exc_store_o)
    );

    assign busy_o = pending || !q_empty;

endmodule

// File: rtl/lsu_bus_chk.sv
`timescale 1ns/1ps
module lsu_bus_chk #(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int BW    = DW / 8,
    parameter int DEPTH = 2
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic          mem_req_o,
    input logic          mem_gnt_i,
    input logic [AW-1:0] mem_addr_o,
    input logic          mem_we_o,
    input logic [BW-1:0] mem_be_o,
    input logic [DW-1:0] mem_wdata_o,
    input logic          mem_rvalid_i,
    input logic          mem_err_i,
    input logic          ld_valid_o,
    input logic [DW-1:0] ld_data_o,
    input logic          st_done_o,
    input logic          exc_o,
    input logic          busy_o
);
    int unanswered_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            unanswered_q <= 0;
        end else begin
            unanswered_q <= unanswered_q
                          + ((mem_req_o && mem_gnt_i) ? 1 : 0)
                          - ((mem_rvalid_i && unanswered_q > 0) ? 1 : 0);
        end
    end

    AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mem_req_o && !mem_gnt_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)
                                       && $stable(mem_be_o) && $stable(mem_wdata_o))); // R3
    AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        unanswered_q <= DEPTH); // R6
    AST_FULL_NO_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (unanswered_q == DEPTH) |-> !mem_req_o); // R6
    AST_LOAD_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ld_valid_o |-> $past(mem_rvalid_i && !mem_err_i)); // R7
    AST_LOAD_DATA_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ld_valid_o |-> $stable(ld_data_o)); // R8
    AST_STORE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_done_o |-> $past(mem_rvalid_i && !mem_err_i)); // R8
    AST_EXC_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        exc_o |-> $past(mem_rvalid_i && mem_err_i)); // R9
    AST_ONE_OUTCOME: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({ld_valid_o, st_done_o, exc_o})); // R9
    AST_BUSY_COVERS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mem_req_o || unanswered_q > 0) |-> busy_o); // R11

endmodule

bind lsu_bus_req lsu_bus_chk #(
    .AW(AW), .DW(DW), .BW(BW), .DEPTH(DEPTH)
) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .mem_req_o    (mem_req_o),
    .mem_gnt_i    (mem_gnt_i),
    .mem_addr_o   (mem_addr_o),
    .mem_we_o     (mem_we_o),
    .mem_be_o     (mem_be_o),
    .mem_wdata_o  (mem_wdata_o),
    .mem_rvalid_i (mem_rvalid_i),
    .mem_err_i    (mem_err_i),
    .ld_valid_o   (ld_valid_o),
    .ld_data_o    (ld_data_o),
    .st_done_o    (st_done_o),
    .exc_o        (exc_o),
    .busy_o       (busy_o)
);

// File: tb/tb_lsu_bus_req.sv
`timescale 1ns/1ps
module tb_lsu_bus_req;
    localparam int AW = 32;
    localparam int DW = 32;
    localparam int BW = DW / 8;
    localparam int DEPTH = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic          cmd_valid = 1'b0, cmd_ready, cmd_we = 1'b0;
    logic [AW-1:0] cmd_addr = '0;
    logic [BW-1:0] cmd_be = '0;
    logic [DW-1:0] cmd_wdata = '0;
    logic          mem_req, mem_gnt = 1'b0, mem_we;
    logic [AW-1:0] mem_addr;
    logic [BW-1:0] mem_be;
    logic [DW-1:0] mem_wdata;
    logic          mem_rvalid = 1'b0, mem_err = 1'b0;
    logic [DW-1:0] mem_rdata = '0;
    logic          ld_valid, st_done, exc, exc_store, busy;
    logic [DW-1:0] ld_data;
    logic [AW-1:0] exc_addr;

    lsu_bus_req #(.AW(AW), .DW(DW), .BW(BW), .DEPTH(DEPTH)) dut (
        .clk_i(clk), .rst_ni(rst_n),
        .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready), .cmd_we_i(cmd_we),
        .cmd_addr_i(cmd_addr), .cmd_be_i(cmd_be), .cmd_wdata_i(cmd_wdata),
        .mem_req_o(mem_req), .mem_gnt_i(mem_gnt), .mem_addr_o(mem_addr),
        .mem_we_o(mem_we), .mem_be_o(mem_be), .mem_wdata_o(mem_wdata),
        .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata), .mem_err_i(mem_err),
        .ld_valid_o(ld_valid), .ld_data_o(ld_data), .st_done_o(st_done),
        .exc_o(exc), .exc_addr_o(exc_addr), .exc_store_o(exc_store), .busy_o(busy)
    );

    int  n_tests = 0;
    int  n_fail = 0;
    bit  finished = 0;
    int  cyc = 0;
    int  txn_id = 0;
    int  last_due = 0;

    typedef struct {
        logic          we;
        logic [AW-1:0] addr;
        logic [DW-1:0] rdata;
        bit            err;
        int            due;
    } rsp_t;
    rsp_t rq[$];

    // Reference state as it will be after the coming clock edge.
    bit            m_pend = 0, m_chain = 0;
    logic [AW-1:0] m_addr = '0;
    logic          m_we = 1'b0;
    logic [BW-1:0] m_be = '0;
    logic [DW-1:0] m_wdata = '0;
    int            m_out = 0;
    bit            e_ldv = 0, e_std = 0, e_exc = 0, e_exc_st = 0;
    logic [AW-1:0] e_exc_addr = '0;
    logic [DW-1:0] e_ld_data = '0;

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    task automatic compare();
        chk(m_pend ? (m_chain ? "R5" : "R2") : "R4", "mem_req_o", 64'(mem_req), 64'(m_pend));
        if (m_pend) begin
            chk(m_chain ? "R5" : "R3", "mem_addr_o", 64'(mem_addr), 64'(m_addr));
            chk("R3", "mem_we_o", 64'(mem_we), 64'(m_we));
            chk("R3", "mem_be_o", 64'(mem_be), 64'(m_be));
            chk("R3", "mem_wdata_o", 64'(mem_wdata), 64'(m_wdata));
        end
        chk("R11", "busy_o", 64'(busy), 64'(m_pend || m_out > 0));
        chk("R7", "ld_valid_o", 64'(ld_valid), 64'(e_ldv));
        chk("R7 R10", "ld_data_o", 64'(ld_data), 64'(e_ld_data));
        chk("R8", "st_done_o", 64'(st_done), 64'(e_std));
        chk("R9", "exc_o", 64'(exc), 64'(e_exc));
        if (e_exc) begin
            chk("R9 R10", "exc_addr_o", 64'(exc_addr), 64'(e_exc_addr));
            chk("R9", "exc_store_o", 64'(exc_store), 64'(e_exc_st));
        end
    endtask

    function automatic logic gen_we(input int p, input int i);
        case (p)
            1:       return 1'b0;
            2, 4:    return 1'(i % 2);
            3:       return 1'((i % 3) == 0);
            default: return 1'((i % 4) < 2);
        endcase
    endfunction

    // p: phase, n: commands, gmax: max grant delay, lmin/lspan: response latency,
    // emode: 0 no errors, 1 alternate errors, 2 all errors.
    task automatic run_phase(input int p, input int n, input int gmax,
                             input int lmin, input int lspan, input int emode);
        int issued = 0;
        int guard = 0;
        int gwait = int'($urandom_range(gmax, 0));
        while ((issued < n || m_pend || m_out > 0) && guard < 4000) begin
            bit   gnt, rv, acc;
            rsp_t cur;
            @(negedge clk);
            cyc++;
            guard++;
            compare();
            gnt = 1'b0;
            if (mem_req) begin
                if (gwait == 0) gnt = 1'b1;
                else gwait--;
            end
            rv = 1'b0;
            cur = '{we: 1'b0, addr: '0, rdata: '0, err: 1'b0, due: 0};
            if (rq.size() > 0 && rq[0].due <= cyc) begin
                cur = rq.pop_front();
                rv = 1'b1;
            end
            mem_gnt    = gnt;
            mem_rvalid = rv;
            mem_err    = rv ? cur.err : 1'b0;
            mem_rdata  = rv ? cur.rdata : 32'h0BAD_0000 ^ DW'(cyc);
            cmd_valid  = (issued < n);
            cmd_we     = gen_we(p, issued);
            cmd_addr   = 32'h1000_0000 + AW'(p * 256) + AW'(issued * 4);
            cmd_be     = cmd_we ? BW'(4'b0001 << (issued % 4)) : '1;
            cmd_wdata  = 32'hA500_0000 ^ cmd_addr;
            #1;
            acc = cmd_valid && cmd_ready;
            if (m_out >= DEPTH && !rv) begin
                chk("R6", "cmd_ready_o when full", 64'(cmd_ready), 64'd0);
            end
            if (!m_pend && m_out < DEPTH) begin
                chk("R6", "cmd_ready_o with room", 64'(cmd_ready), 64'd1);
            end
            if (gnt) begin
                rsp_t nr;
                int   due = cyc + lmin + int'($urandom_range(lspan, 0));
                if (due <= last_due) due = last_due + 1;
                last_due = due;
                nr.we    = m_we;
                nr.addr  = m_addr;
                nr.rdata = m_we ? 32'hDEAD_0000 ^ DW'(txn_id) : ~m_addr;
                nr.err   = (emode == 2) || (emode == 1 && (txn_id % 2) == 1);
                nr.due   = due;
                rq.push_back(nr);
                txn_id++;
                m_out++;
                gwait = int'($urandom_range(gmax, 0));
            end
            e_ldv = 0; e_std = 0; e_exc = 0;
            if (rv) begin
                m_out--;
                if (cur.err) begin
                    e_exc = 1; e_exc_addr = cur.addr; e_exc_st = cur.we;
                end else if (cur.we) begin
                    e_std = 1;
                end else begin
                    e_ldv = 1; e_ld_data = cur.rdata;
                end
            end
            m_chain = 0;
            if (acc) begin
                m_chain = m_pend;
                m_pend  = 1;
                m_addr  = cmd_addr; m_we = cmd_we; m_be = cmd_be; m_wdata = cmd_wdata;
                issued++;
            end else if (gnt) begin
                m_pend = 0;
            end
        end
        chk("R10", "phase drained", 64'(guard < 4000), 64'd1);
        @(negedge clk);
        cyc++;
        compare();
        mem_gnt = 1'b0; mem_rvalid = 1'b0; mem_err = 1'b0; cmd_valid = 1'b0;
        e_ldv = 0; e_std = 0; e_exc = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1", "mem_req_o", 64'(mem_req), 64'd0);
        chk("R1", "busy_o", 64'(busy), 64'd0);
        chk("R1", "cmd_ready_o", 64'(cmd_ready), 64'd1);
        chk("R1", "pulses", 64'({ld_valid, st_done, exc}), 64'd0);
        chk("R1", "ld_data_o", 64'(ld_data), 64'd0);
        run_phase(1, 16, 0, 1, 0, 0);   // R2 R5 R7: loads, instant grant, back to back
        run_phase(2, 20, 3, 1, 3, 0);   // R3 R8: stalled grants, mixed
        run_phase(3, 20, 0, 6, 2, 0);   // R6: slow responses fill the queue
        run_phase(4, 20, 2, 1, 2, 1);   // R9 R10: alternating errors
        run_phase(5, 12, 1, 1, 1, 2);   // R9: every access fails
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog all requirements actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule